// File: doc/BRIEF.md
# Fixed-Priority Four-by-Four AXI Crossbar

This block joins four bus masters to four bus targets over a reduced AXI4-style protocol in which every channel moves one beat under a VALID/READY handshake. A beat is taken only in a cycle where the sender's VALID and the receiver's READY are both high. Each master has a read-address channel, a read-data channel, a write-request channel that carries address and data together, and a write-response channel. Every target has the same channels in the other direction. The two top address bits choose the target. Each target has its own arbiter and multiplexer.

When several masters want an idle target in the same cycle, the lowest-numbered master wins. A master that presents a read and a write together has its read served first. A grant is registered. It covers the request handshake and then the matching response handshake. Once the response handshake completes, the target is free again and is arbitrated in the next cycle. A master that is waiting sees READY low, and it keeps VALID high until it is served.

Top module: `prio_axi_xbar`

## Requirements
- R1: The target of a request is given by address bits [ADDR_W-1:ADDR_W-2] (value 0 to 3). Request address and data reach only that target's port, unchanged.
- R2: A master's READY on a request channel is high only in a cycle where its granted target raises READY for that master's own forwarded request. A master that has not been granted sees READY low.
- R3: Among the masters requesting an idle target in a cycle, the lowest index gets the grant.
- R4: A master with read VALID high is not granted for its write. When it presents both at once, its read handshake comes first.
- R5: A request that reaches an idle target with no contention is granted at the next rising edge. It appears at the target's port in the following cycle, which is one cycle after the request was first driven.
- R6: A target stays owned by one master from the grant until the response handshake for that transfer completes. While a forwarded request waits for READY, its VALID and address hold. Re-arbitration happens in the cycle after the response handshake.
- R7: A read-data beat or write-response beat from a target goes only to the master that owns that target. The master's response READY is passed back to the target.
- R8: Each master has at most one read and at most one write outstanding. Every accepted request produces exactly one response.
- R9: During reset, and in the first cycle after it, no request VALID reaches any target and no READY reaches any master.
- R10: Write data travels with its write address. The target receives the data the master drove for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_ar_valid | input | NM | Read request valid, one bit per master |
| m_ar_addr | input | NM x ADDR_W | Read address per master |
| m_ar_ready | output | NM | Read request accepted |
| m_r_valid | output | NM | Read data valid toward master |
| m_r_data | output | NM x DATA_W | Read data toward master |
| m_r_ready | input | NM | Master takes read data |
| m_aw_valid | input | NM | Write request valid (address and data) |
| m_aw_addr | input | NM x ADDR_W | Write address per master |
| m_w_data | input | NM x DATA_W | Write data per master |
| m_aw_ready | output | NM | Write request accepted |
| m_b_valid | output | NM | Write response valid toward master |
| m_b_ready | input | NM | Master takes write response |
| s_ar_valid | output | NS | Read request valid toward target |
| s_ar_addr | output | NS x ADDR_W | Read address toward target |
| s_ar_ready | input | NS | Target accepts read request |
| s_r_valid | input | NS | Target read data valid |
| s_r_data | input | NS x DATA_W | Target read data |
| s_r_ready | output | NS | Read data taken by owning master |
| s_aw_valid | output | NS | Write request valid toward target |
| s_aw_addr | output | NS x ADDR_W | Write address toward target |
| s_w_data | output | NS x DATA_W | Write data toward target |
| s_aw_ready | input | NS | Target accepts write request |
| s_b_valid | input | NS | Target write response valid |
| s_b_ready | output | NS | Write response taken by owning master |

## Verification
A request seen in cycle k is granted at the edge that ends cycle k. It shows at the target port, and can be accepted, in cycle k+1. Responses and READY pass through in the same cycle they arrive. A freed target takes a new grant at the edge after the response handshake. The bench drives inputs on the falling edge and samples 5 ns before the next rising edge. It checks every target-side and master-side VALID/READY and every routed address and data word against a behavioural ownership model in that same cycle. Handshakes are counted at the edge they complete on.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_RESP = 2'd2
    } phase_e;
endpackage

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode #(
    parameter int NM = 4,
    parameter int NS = 4,
    parameter int A  = 32
) (
    input  logic [NM-1:0][A-1:0] addr,
    output logic [NS-1:0][NM-1:0] hit
);
    localparam int SW = $clog2(NS);

    for (genvar s = 0; s < NS; s++) begin : g_tgt
        for (genvar m = 0; m < NM; m++) begin : g_src
            assign hit[s][m] = (addr[m][A-1 -: SW] == SW'(s));
        end
    end
endmodule

// File: rtl/xbar_prio_pick.sv
module xbar_prio_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xbar_target_port.sv
module xbar_target_port
    import xbar_pkg::*;
#(
    parameter int NM = 4,
    parameter int A  = 32,
    parameter int D  = 32,
    localparam int IW = $clog2(NM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NM-1:0]        ar_valid,
    input  logic [NM-1:0]        ar_hit,
    input  logic [NM-1:0][A-1:0] ar_addr,
    input  logic [NM-1:0]        aw_valid,
    input  logic [NM-1:0]        aw_hit,
    input  logic [NM-1:0][A-1:0] aw_addr,
    input  logic [NM-1:0][D-1:0] w_data,
    input  logic [NM-1:0]        r_ready,
    input  logic [NM-1:0]        b_ready,
    input  logic [NM-1:0]        rd_busy,
    input  logic [NM-1:0]        wr_busy,
    input  logic                 t_ar_ready,
    input  logic                 t_aw_ready,
    input  logic                 t_r_valid,
    input  logic                 t_b_valid,
    output logic                 t_ar_valid,
    output logic [A-1:0]         t_ar_addr,
    output logic                 t_aw_valid,
    output logic [A-1:0]         t_aw_addr,
    output logic [D-1:0]         t_w_data,
    output logic                 t_r_ready,
    output logic                 t_b_ready,
    output logic [NM-1:0]        ar_ready_v,
    output logic [NM-1:0]        aw_ready_v,
    output logic [NM-1:0]        r_valid_v,
    output logic [NM-1:0]        b_valid_v,
    output logic [NM-1:0]        rd_own_v,
    output logic [NM-1:0]        wr_own_v
);
    typedef struct packed {
        phase_e        ph;
        logic [IW-1:0] idx;
        logic          rd;
    } slot_t;

    slot_t st_q, st_d;

    logic [NM-1:0] rd_req, wr_req;
    logic          win_any;
    logic [IW-1:0] win_idx;

    // a pending read of the same master holds back its write
    assign rd_req = ar_valid & ar_hit & ~rd_busy;
    assign wr_req = aw_valid & aw_hit & ~ar_valid & ~wr_busy;

    xbar_prio_pick #(.N(NM)) u_pick (
        .req (rd_req | wr_req),
        .any (win_any),
        .idx (win_idx)
    );

    logic in_addr, in_resp;
    assign in_addr = (st_q.ph == PH_ADDR);
    assign in_resp = (st_q.ph == PH_RESP);

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (win_any) begin
                    st_d.ph  = PH_ADDR;
                    st_d.idx = win_idx;
                    st_d.rd  = rd_req[win_idx];
                end
            end
            PH_ADDR: begin
                if (st_q.rd) begin
                    if (ar_valid[st_q.idx] && t_ar_ready) st_d.ph = PH_RESP;
                end else begin
                    if (aw_valid[st_q.idx] && t_aw_ready) st_d.ph = PH_RESP;
                end
            end
            PH_RESP: begin
                if (st_q.rd) begin
                    if (t_r_valid && r_ready[st_q.idx]) st_d.ph = PH_IDLE;
                end else begin
                    if (t_b_valid && b_ready[st_q.idx]) st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, idx: '0, rd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // target-side forwarding
    assign t_ar_valid = in_addr && st_q.rd && ar_valid[st_q.idx];
    assign t_ar_addr  = ar_addr[st_q.idx];
    assign t_aw_valid = in_addr && !st_q.rd && aw_valid[st_q.idx];
    assign t_aw_addr  = aw_addr[st_q.idx];
    assign t_w_data   = w_data[st_q.idx];
    assign t_r_ready  = in_resp && st_q.rd && r_ready[st_q.idx];
    assign t_b_ready  = in_resp && !st_q.rd && b_ready[st_q.idx];

    // master-side return paths, one bit per master
    for (genvar m = 0; m < NM; m++) begin : g_ret
        logic own;
        assign own           = (st_q.idx == IW'(m));
        assign ar_ready_v[m] = own && in_addr && st_q.rd && t_ar_ready;
        assign aw_ready_v[m] = own && in_addr && !st_q.rd && t_aw_ready;
        assign r_valid_v[m]  = own && in_resp && st_q.rd && t_r_valid;
        assign b_valid_v[m]  = own && in_resp && !st_q.rd && t_b_valid;
        assign rd_own_v[m]   = own && (st_q.ph != PH_IDLE) && st_q.rd;
        assign wr_own_v[m]   = own && (st_q.ph != PH_IDLE) && !st_q.rd;
    end
endmodule

// File: rtl/prio_axi_xbar.sv
module prio_axi_xbar #(
    parameter int NM     = 4,
    parameter int NS     = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NM-1:0]             m_ar_valid,
    input  logic [NM-1:0][ADDR_W-1:0] m_ar_addr,
    output logic [NM-1:0]             m_ar_ready,
    output logic [NM-1:0]             m_r_valid,
    output logic [NM-1:0][DATA_W-1:0] m_r_data,
    input  logic [NM-1:0]             m_r_ready,
    input  logic [NM-1:0]             m_aw_valid,
    input  logic [NM-1:0][ADDR_W-1:0] m_aw_addr,
    input  logic [NM-1:0][DATA_W-1:0] m_w_data,
    output logic [NM-1:0]             m_aw_ready,
    output logic [NM-1:0]             m_b_valid,
    input  logic [NM-1:0]             m_b_ready,
    output logic [NS-1:0]             s_ar_valid,
    output logic [NS-1:0][ADDR_W-1:0] s_ar_addr,
    input  logic [NS-1:0]             s_ar_ready,
    input  logic [NS-1:0]             s_r_valid,
    input  logic [NS-1:0][DATA_W-1:0] s_r_data,
    output logic [NS-1:0]             s_r_ready,
    output logic [NS-1:0]             s_aw_valid,
    output logic [NS-1:0][ADDR_W-1:0] s_aw_addr,
    output logic [NS-1:0][DATA_W-1:0] s_w_data,
    input  logic [NS-1:0]             s_aw_ready,
    input  logic [NS-1:0]             s_b_valid,
    output logic [NS-1:0]             s_b_ready
);
    logic [NS-1:0][NM-1:0] ar_hit, aw_hit;
    logic [NS-1:0][NM-1:0] arr_v, awr_v, rv_v, bv_v, rown_v, wown_v;
    logic [NM-1:0]         rd_busy, wr_busy;

    xbar_addr_decode #(.NM(NM), .NS(NS), .A(ADDR_W)) u_dec_rd (
        .addr (m_ar_addr),
        .hit  (ar_hit)
    );

    xbar_addr_decode #(.NM(NM), .NS(NS), .A(ADDR_W)) u_dec_wr (
        .addr (m_aw_addr),
        .hit  (aw_hit)
    );

    for (genvar s = 0; s < NS; s++) begin : g_port
        xbar_target_port #(.NM(NM), .A(ADDR_W), .D(DATA_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .ar_valid   (m_ar_valid),
            .ar_hit     (ar_hit[s]),
            .ar_addr    (m_ar_addr),
            .aw_valid   (m_aw_valid),
            .aw_hit     (aw_hit[s]),
            .aw_addr    (m_aw_addr),
            .w_data     (m_w_data),
            .r_ready    (m_r_ready),
            .b_ready    (m_b_ready),
            .rd_busy    (rd_busy),
            .wr_busy    (wr_busy),
            .t_ar_ready (s_ar_ready[s]),
            .t_aw_ready (s_aw_ready[s]),
            .t_r_valid  (s_r_valid[s]),
            .t_b_valid  (s_b_valid[s]),
            .t_ar_valid (s_ar_valid[s]),
            .t_ar_addr  (s_ar_addr[s]),
            .t_aw_valid (s_aw_valid[s]),
            .t_aw_addr  (s_aw_addr[s]),
            .t_w_data   (s_w_data[s]),
            .t_r_ready  (s_r_ready[s]),
            .t_b_ready  (s_b_ready[s]),
            .ar_ready_v (arr_v[s]),
            .aw_ready_v (awr_v[s]),
            .r_valid_v  (rv_v[s]),
            .b_valid_v  (bv_v[s]),
            .rd_own_v   (rown_v[s]),
            .wr_own_v   (wown_v[s])
        );
    end

    // ownership seen by every arbiter (from registered state only)
    always_comb begin
        rd_busy = '0;
        wr_busy = '0;
        for (int s = 0; s < NS; s++) begin
            rd_busy = rd_busy | rown_v[s];
            wr_busy = wr_busy | wown_v[s];
        end
    end

    always_comb begin
        m_ar_ready = '0;
        m_aw_ready = '0;
        m_r_valid  = '0;
        m_b_valid  = '0;
        for (int s = 0; s < NS; s++) begin
            m_ar_ready = m_ar_ready | arr_v[s];
            m_aw_ready = m_aw_ready | awr_v[s];
            m_r_valid  = m_r_valid | rv_v[s];
            m_b_valid  = m_b_valid | bv_v[s];
        end
    end

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_r_data[m] = '0;
            for (int s = 0; s < NS; s++) begin
                if (rv_v[s][m]) m_r_data[m] = m_r_data[m] | s_r_data[s];
            end
        end
    end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
    parameter int NM     = 4,
    parameter int NS     = 4,
    parameter int ADDR_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NM-1:0]             m_ar_valid,
    input logic [NM-1:0]             m_ar_ready,
    input logic [NM-1:0]             m_aw_valid,
    input logic [NM-1:0]             m_aw_ready,
    input logic [NM-1:0]             m_r_valid,
    input logic [NM-1:0]             m_r_ready,
    input logic [NM-1:0]             m_b_valid,
    input logic [NM-1:0]             m_b_ready,
    input logic [NS-1:0]             s_ar_valid,
    input logic [NS-1:0]             s_ar_ready,
    input logic [NS-1:0][ADDR_W-1:0] s_ar_addr,
    input logic [NS-1:0]             s_aw_valid,
    input logic [NS-1:0][ADDR_W-1:0] s_aw_addr
);
    localparam int SW = $clog2(NS);

    logic [NM-1:0] rd_pend, wr_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= '0;
            wr_pend <= '0;
        end else begin
            rd_pend <= (rd_pend | (m_ar_valid & m_ar_ready)) & ~(m_r_valid & m_r_ready);
            wr_pend <= (wr_pend | (m_aw_valid & m_aw_ready)) & ~(m_b_valid & m_b_ready);
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (s_ar_valid == '0 && s_aw_valid == '0 && m_ar_ready == '0 && m_aw_ready == '0)); // R9

    for (genvar m = 0; m < NM; m++) begin : g_m
        AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            m_ar_ready[m] |-> m_ar_valid[m]); // R2
        AST_WREADY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            m_aw_ready[m] |-> m_aw_valid[m]); // R2
        AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            (m_ar_valid[m] && m_ar_ready[m]) |-> !rd_pend[m]); // R8
        AST_ONE_WRITE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            (m_aw_valid[m] && m_aw_ready[m]) |-> !wr_pend[m]); // R8
        AST_RDATA_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            m_r_valid[m] |-> rd_pend[m]); // R7
        AST_BRESP_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            m_b_valid[m] |-> wr_pend[m]); // R7
    end

    for (genvar s = 0; s < NS; s++) begin : g_s
        AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (s_ar_valid[s] && !s_ar_ready[s]) |=> (s_ar_valid[s] && $stable(s_ar_addr[s]))); // R6
        AST_ONE_KIND_PER_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            !(s_ar_valid[s] && s_aw_valid[s])); // R6
        AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
            s_ar_valid[s] |-> (s_ar_addr[s][ADDR_W-1 -: SW] == SW'(s))); // R1
        AST_WRITE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
            s_aw_valid[s] |-> (s_aw_addr[s][ADDR_W-1 -: SW] == SW'(s))); // R1
    end
endmodule

bind prio_axi_xbar xbar_checker #(.NM(NM), .NS(NS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_prio_axi_xbar.sv
`timescale 1ns/1ps
module test_prio_axi_xbar;
    localparam logic [31:0] WKEY = 32'h5A5A_5A5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0]        m_ar_valid, m_ar_ready, m_r_valid, m_r_ready;
    logic [3:0]        m_aw_valid, m_aw_ready, m_b_valid, m_b_ready;
    logic [3:0][31:0]  m_ar_addr, m_r_data, m_aw_addr, m_w_data;
    logic [3:0]        s_ar_valid, s_ar_ready, s_r_valid, s_r_ready;
    logic [3:0]        s_aw_valid, s_aw_ready, s_b_valid, s_b_ready;
    logic [3:0][31:0]  s_ar_addr, s_r_data, s_aw_addr, s_w_data;

    prio_axi_xbar i_prio_axi_xbar (
        .clk(clk), .rst_n(rst_n),
        .m_ar_valid(m_ar_valid), .m_ar_addr(m_ar_addr), .m_ar_ready(m_ar_ready),
        .m_r_valid(m_r_valid), .m_r_data(m_r_data), .m_r_ready(m_r_ready),
        .m_aw_valid(m_aw_valid), .m_aw_addr(m_aw_addr), .m_w_data(m_w_data),
        .m_aw_ready(m_aw_ready), .m_b_valid(m_b_valid), .m_b_ready(m_b_ready),
        .s_ar_valid(s_ar_valid), .s_ar_addr(s_ar_addr), .s_ar_ready(s_ar_ready),
        .s_r_valid(s_r_valid), .s_r_data(s_r_data), .s_r_ready(s_r_ready),
        .s_aw_valid(s_aw_valid), .s_aw_addr(s_aw_addr), .s_w_data(s_w_data),
        .s_aw_ready(s_aw_ready), .s_b_valid(s_b_valid), .s_b_ready(s_b_ready)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit rnd = 0;
    // master-side bench state
    bit          ar_v[4], aw_v[4];
    logic [31:0] ar_a[4], aw_a[4], rexp[4];
    int          rd_out[4], wr_out[4], ar_cyc[4], aw_cyc[4];
    int          issued = 0, done = 0;
    int          acc_q[$];
    // target-side bench state
    bit          sl_rp[4], sl_bp[4];
    logic [31:0] sl_rd[4];
    // reference ownership model: phase 0 idle, 1 request, 2 response
    int          mph[4], mown[4];
    bit          mrd[4];

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s (cycle %0d) actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        logic [3:0] e_sarv, e_sawv, e_srr, e_sbr, e_mar, e_maw, e_mrv, e_mbv;
        bit addr_ok;
        bit busy_r[4], busy_w[4];
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            m_ar_valid[m] = ar_v[m];
            m_ar_addr[m]  = ar_a[m];
            m_aw_valid[m] = aw_v[m];
            m_aw_addr[m]  = aw_a[m];
            m_w_data[m]   = aw_a[m] ^ WKEY;
            m_r_ready[m]  = rnd ? 1'($urandom % 2) : 1'b1;
            m_b_ready[m]  = rnd ? 1'($urandom % 2) : 1'b1;
        end
        for (int s = 0; s < 4; s++) begin
            s_ar_ready[s] = rnd ? 1'($urandom % 2) : 1'b1;
            s_aw_ready[s] = rnd ? 1'($urandom % 2) : 1'b1;
            s_r_valid[s]  = sl_rp[s];
            s_r_data[s]   = sl_rd[s];
            s_b_valid[s]  = sl_bp[s];
        end
        #5;
        // expected outputs from the ownership model
        e_sarv = '0; e_sawv = '0; e_srr = '0; e_sbr = '0;
        e_mar = '0; e_maw = '0; e_mrv = '0; e_mbv = '0;
        addr_ok = 1'b1;
        for (int s = 0; s < 4; s++) begin
            int o;
            o = mown[s];
            if (mph[s] == 1 && mrd[s]) begin
                e_sarv[s] = m_ar_valid[o];
                e_mar[o]  = s_ar_ready[s];
                if (m_ar_valid[o] && s_ar_addr[s] != m_ar_addr[o]) addr_ok = 1'b0;
            end
            if (mph[s] == 1 && !mrd[s]) begin
                e_sawv[s] = m_aw_valid[o];
                e_maw[o]  = s_aw_ready[s];
                if (m_aw_valid[o] && (s_aw_addr[s] != m_aw_addr[o] || s_w_data[s] != m_w_data[o])) addr_ok = 1'b0;
            end
            if (mph[s] == 2 && mrd[s]) begin
                e_srr[s] = m_r_ready[o];
                e_mrv[o] = s_r_valid[s];
                if (s_r_valid[s] && m_r_data[o] != s_r_data[s]) addr_ok = 1'b0;
            end
            if (mph[s] == 2 && !mrd[s]) begin
                e_sbr[s] = m_b_ready[o];
                e_mbv[o] = s_b_valid[s];
            end
        end
        // R3 R5 R6: target-side grants and routing
        chk(s_ar_valid == e_sarv && s_aw_valid == e_sawv && s_r_ready == e_srr && s_b_ready == e_sbr && addr_ok,
            "R3/R5/R6 target side", {16'h0, s_ar_valid, s_aw_valid, s_r_ready, s_b_ready},
            {16'h0, e_sarv, e_sawv, e_srr, e_sbr});
        // R2 R7: master-side ready and response steering
        chk(m_ar_ready == e_mar && m_aw_ready == e_maw && m_r_valid == e_mrv && m_b_valid == e_mbv,
            "R2/R7 master side", {16'h0, m_ar_ready, m_aw_ready, m_r_valid, m_b_valid},
            {16'h0, e_mar, e_maw, e_mrv, e_mbv});
        // master handshakes
        for (int m = 0; m < 4; m++) begin
            if (m_ar_valid[m] && m_ar_ready[m]) begin
                ar_v[m] = 0; rd_out[m]++; rexp[m] = ar_a[m]; ar_cyc[m] = cyc; acc_q.push_back(m);
            end
            if (m_aw_valid[m] && m_aw_ready[m]) begin
                aw_v[m] = 0; wr_out[m]++; aw_cyc[m] = cyc;
            end
            if (m_r_valid[m] && m_r_ready[m]) begin
                chk(rd_out[m] == 1 && m_r_data[m] == ~rexp[m], "R7/R8 read return", m_r_data[m], ~rexp[m]);
                rd_out[m]--; done++;
            end
            if (m_b_valid[m] && m_b_ready[m]) begin
                chk(wr_out[m] == 1, "R8 write response", 32'(wr_out[m]), 32'd1);
                wr_out[m]--; done++;
            end
        end
        // target handshakes
        for (int s = 0; s < 4; s++) begin
            if (s_ar_valid[s] && s_ar_ready[s]) begin
                chk(s_ar_addr[s][31:30] == 2'(s), "R1 read decode", s_ar_addr[s], 32'(s));
                sl_rp[s] = 1; sl_rd[s] = ~s_ar_addr[s];
            end
            if (s_aw_valid[s] && s_aw_ready[s]) begin
                chk(s_aw_addr[s][31:30] == 2'(s), "R1 write decode", s_aw_addr[s], 32'(s));
                chk(s_w_data[s] == (s_aw_addr[s] ^ WKEY), "R10 write data", s_w_data[s], s_aw_addr[s] ^ WKEY);
                sl_bp[s] = 1;
            end
            if (s_r_valid[s] && s_r_ready[s]) sl_rp[s] = 0;
            if (s_b_valid[s] && s_b_ready[s]) sl_bp[s] = 0;
        end
        // model update
        for (int m = 0; m < 4; m++) begin busy_r[m] = 0; busy_w[m] = 0; end
        for (int s = 0; s < 4; s++) begin
            if (mph[s] != 0) begin
                if (mrd[s]) busy_r[mown[s]] = 1; else busy_w[mown[s]] = 1;
            end
        end
        for (int s = 0; s < 4; s++) begin
            if (mph[s] == 1) begin
                if (mrd[s] ? (s_ar_valid[s] && s_ar_ready[s]) : (s_aw_valid[s] && s_aw_ready[s])) mph[s] = 2;
            end else if (mph[s] == 2) begin
                if (mrd[s] ? (s_r_valid[s] && s_r_ready[s]) : (s_b_valid[s] && s_b_ready[s])) mph[s] = 0;
            end else begin
                for (int m = 0; m < 4; m++) begin
                    bit rq, wq;
                    rq = m_ar_valid[m] && m_ar_addr[m][31:30] == 2'(s) && !busy_r[m];
                    wq = m_aw_valid[m] && m_aw_addr[m][31:30] == 2'(s) && !m_ar_valid[m] && !busy_w[m];
                    if (mph[s] == 0 && (rq || wq)) begin
                        mph[s] = 1; mown[s] = m; mrd[s] = rq;
                    end
                end
            end
        end
        // new random traffic
        if (rnd) begin
            for (int m = 0; m < 4; m++) begin
                if (!ar_v[m] && $urandom % 3 == 0) begin ar_v[m] = 1; ar_a[m] = $urandom; issued++; end
                if (!aw_v[m] && $urandom % 3 == 0) begin aw_v[m] = 1; aw_a[m] = $urandom; issued++; end
            end
        end
        cyc++;
    endtask

    function automatic bit all_quiet();
        bit q = 1;
        for (int i = 0; i < 4; i++) begin
            if (ar_v[i] || aw_v[i] || rd_out[i] != 0 || wr_out[i] != 0 || sl_rp[i] || sl_bp[i] || mph[i] != 0) q = 0;
        end
        return q;
    endfunction

    task automatic drain();
        for (int k = 0; k < 600 && !all_quiet(); k++) step();
    endtask

    initial begin : watchdog
        #(150000 * 20);
        nerr++; nchk++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int c0;
        for (int i = 0; i < 4; i++) begin
            ar_v[i] = 0; aw_v[i] = 0; rd_out[i] = 0; wr_out[i] = 0; sl_rp[i] = 0; sl_bp[i] = 0;
            mph[i] = 0; mown[i] = 0; mrd[i] = 0; ar_a[i] = '0; aw_a[i] = '0; rexp[i] = '0; sl_rd[i] = '0;
        end
        // R9: requests and readies driven during reset must not pass
        m_ar_valid = '1; m_aw_valid = '1; m_ar_addr = '0; m_aw_addr = '0; m_w_data = '0;
        m_r_ready = '1; m_b_ready = '1;
        s_ar_ready = '1; s_aw_ready = '1; s_r_valid = '0; s_b_valid = '0; s_r_data = '0;
        repeat (3) @(negedge clk);
        #5;
        chk(s_ar_valid == 0 && s_aw_valid == 0 && m_ar_ready == 0 && m_aw_ready == 0 && m_r_valid == 0 && m_b_valid == 0,
            "R9 reset state", {16'h0, s_ar_valid, s_aw_valid, m_ar_ready, m_aw_ready}, 32'h0);
        @(negedge clk);
        m_ar_valid = '0; m_aw_valid = '0;
        rst_n = 1'b1;
        step();
        chk(s_ar_valid == 0 && s_aw_valid == 0 && m_ar_ready == 0, "R9 first cycle after reset",
            {24'h0, s_ar_valid, m_ar_ready}, 32'h0);

        // R5 + R1: lone read to target 3 is accepted one cycle after it is driven
        ar_v[2] = 1; ar_a[2] = 32'hC000_0010;
        c0 = cyc;
        drain();
        chk(ar_cyc[2] == c0 + 1, "R5 grant latency", 32'(ar_cyc[2]), 32'(c0 + 1));

        // R3: all four masters read target 2 at once
        acc_q.delete();
        for (int m = 0; m < 4; m++) begin ar_v[m] = 1; ar_a[m] = 32'h8000_0000 | 32'(m * 4); end
        drain();
        chk(acc_q.size() == 4, "R3 contention count", 32'(acc_q.size()), 32'd4);
        for (int i = 0; i < 4 && i < acc_q.size(); i++)
            chk(acc_q[i] == i, "R3 priority order", 32'(acc_q[i]), 32'(i));

        // R3: masters 1 and 3 on target 0, master 2 on target 1
        acc_q.delete();
        ar_v[1] = 1; ar_a[1] = 32'h0000_0100;
        ar_v[3] = 1; ar_a[3] = 32'h0000_0300;
        ar_v[2] = 1; ar_a[2] = 32'h4000_0200;
        drain();
        chk(acc_q.size() == 3 && acc_q[0] == 1 && acc_q[1] == 2 && acc_q[2] == 3, "R3 mixed contention",
            32'(acc_q.size()), 32'd3);

        // R4: one master, read and write together on different targets
        ar_v[1] = 1; ar_a[1] = 32'h0000_0020;
        aw_v[1] = 1; aw_a[1] = 32'hC000_0040;
        drain();
        chk(ar_cyc[1] < aw_cyc[1], "R4 read before write, two targets", 32'(ar_cyc[1]), 32'(aw_cyc[1]));

        // R4: one master, read and write together on the same target
        ar_v[0] = 1; ar_a[0] = 32'h8000_0044;
        aw_v[0] = 1; aw_a[0] = 32'h8000_0048;
        drain();
        chk(ar_cyc[0] < aw_cyc[0], "R4 read before write, one target", 32'(ar_cyc[0]), 32'(aw_cyc[0]));

        // random concurrent traffic with random back-pressure
        issued = 0; done = 0;
        rnd = 1;
        repeat (4000) step();
        rnd = 0;
        drain();
        chk(all_quiet(), "R8 all transfers drained", 32'(all_quiet()), 32'd1);
        chk(done == issued, "R8 no lost or duplicated transfer", 32'(done), 32'(issued));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule